// File: doc/BRIEF.md
# NAND Flash Block Erase Sequencer

This block is a host-side controller that erases one block of an 8-bit NAND flash device. On a start pulse it captures a row address. It then drives the flash bus through the two-step erase: the setup command, three row-address bytes and the confirm command. Every byte is written with its own write-enable strobe, and the chip-enable, command-latch and address-latch lines are set for that byte.

Once the confirm byte is written, the sequencer waits a fixed settling time. It then watches the open-drain ready/busy line until the device reports ready. Next it writes the status command and reads one status byte, which it decodes into a pass flag and a write-protect flag. A watchdog on the busy wait ends the operation with a timeout flag if the device stays busy too long. All pin widths are counted in clock cycles set by parameters.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset and while idle, `busy`, `done`, `pass`, `wpFault` and `timeout` are 0. Chip-enable, write-enable and read-enable (all active low) are 1, and the command-latch and address-latch lines are 0.
- R2: A start is taken only while idle. A start pulse given during an operation launches nothing: the operation still makes exactly six bus writes, and the block is idle afterwards.
- R3: Each operation writes the following bytes in this order, each latched on the rising edge of write-enable while chip-enable is low: 0x60 with the command latch high, three address bytes with the address latch high, 0xD0 with the command latch high, and 0x70 with the command latch high. The command and address latches are never high together.
- R4: The address bytes carry the 24-bit row address least-significant byte first. The low `PAGE_BITS` bits (default 6) are forced to zero.
- R5: Each write-enable low pulse lasts `WE_LOW` cycles, and write-enable stays high for `WE_HIGH` cycles between bytes. Each read-enable low pulse lasts `RE_LOW` cycles.
- R6: The 0x70 status command is written only after the confirm byte, after a wait of `WB_CYC` cycles, and after ready/busy has been sampled high. The status byte is read while read-enable is low.
- R7: `pass` is 1 only when status bit 0 is 0 (erase succeeded) and status bit 7 is 1 (not protected).
- R8: `wpFault` is 1 when status bit 7 is 0, and `pass` is then 0 whatever bit 0 holds.
- R9: If ready/busy stays low for `TIMEOUT_CYC` cycles of the busy wait, the operation ends with `timeout` = 1 and `pass` = 0, and no status command is written.
- R10: `done` pulses for exactly one cycle at the end of each operation. `pass`, `wpFault` and `timeout` are valid in that cycle and hold until the next start. `busy` is 1 from the cycle after the start up to and including the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken when idle |
| rowAddr | input | 24 | Row address of the block to erase |
| nandRbN | input | 1 | Device ready (1) / busy (0) |
| nandIoIn | input | 8 | Data from the device I/O bus |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| pass | output | 1 | Erase succeeded |
| wpFault | output | 1 | Device reported write protection |
| timeout | output | 1 | Busy wait exceeded its limit |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write enable, active low |
| nandReN | output | 1 | Read enable, active low |
| nandIoOut | output | 8 | Byte driven onto the I/O bus |
| nandIoOe | output | 1 | I/O output enable |

## Verification
The bus bytes are captured at the instant write-enable rises, and the strobe widths are measured in whole cycles at falling clock edges. This makes the byte order, the latch lines and the R5 widths independent of the time the device model takes to finish. The result flags are due in the same cycle as the `done` pulse, so the bench checks them on the falling edge inside that cycle. One cycle later it checks that `done` has dropped while the flags still hold. A timeout is due `TIMEOUT_CYC` cycles into the busy wait, which is why the device model stays busy longer than that window plus the settling wait.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_HI,
    ST_WAIT_WB,
    ST_WAIT_RDY,
    ST_RD_LO,
    ST_FIN
  } seqState_t;

  typedef struct packed {
    logic loadAddr;
    logic cntClr;
    logic cntInc;
    logic idxInc;
    logic capStat;
    logic setTmo;
  } dpCtrl_t;

  localparam logic [7:0] CMD_SETUP   = 8'h60;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam int ADDR_BYTES  = 3;
  localparam int IDX_CONFIRM = 4;
  localparam int IDX_STATUS  = 5;

endpackage

// File: rtl/nand_erase_dp.sv
module nand_erase_dp
  import nand_erase_pkg::*;
#(
  parameter int PAGE_BITS = 6,
  parameter int CNT_W     = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtrl_t                 ctl,
  input  logic [8*ADDR_BYTES-1:0] rowAddr,
  input  logic [7:0]              ioIn,
  output logic [CNT_W-1:0]        cnt,
  output logic [2:0]              idx,
  output logic [7:0]              ioByte,
  output logic                    isCmd,
  output logic                    pass,
  output logic                    wpFault,
  output logic                    timeout
);

  localparam int ROW_W = 8 * ADDR_BYTES;
  localparam logic [ROW_W-1:0] PAGE_MASK = ROW_W'((1 << PAGE_BITS) - 1);

  logic [ROW_W-1:0] rowReg;
  logic [7:0]       addrByte [ADDR_BYTES];
  logic             unusedIo;

  assign unusedIo = ^ioIn[6:1];

  genvar g;
  generate
    for (g = 0; g < ADDR_BYTES; g++) begin : gAddr
      assign addrByte[g] = rowReg[8*g +: 8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg  <= '0;
      cnt     <= '0;
      idx     <= '0;
      pass    <= 1'b0;
      wpFault <= 1'b0;
      timeout <= 1'b0;
    end else begin
      if (ctl.loadAddr) rowReg <= rowAddr & ~PAGE_MASK;
      if (ctl.cntClr)      cnt <= '0;
      else if (ctl.cntInc) cnt <= cnt + 1'b1;
      if (ctl.loadAddr)    idx <= '0;
      else if (ctl.idxInc) idx <= idx + 1'b1;
      if (ctl.loadAddr) begin
        pass    <= 1'b0;
        wpFault <= 1'b0;
        timeout <= 1'b0;
      end else begin
        if (ctl.capStat) begin
          pass    <= ~ioIn[0] & ioIn[7];
          wpFault <= ~ioIn[7];
        end
        if (ctl.setTmo) timeout <= 1'b1;
      end
    end
  end

  always_comb begin
    case (idx)
      3'd0:    ioByte = CMD_SETUP;
      3'd1:    ioByte = addrByte[0];
      3'd2:    ioByte = addrByte[1];
      3'd3:    ioByte = addrByte[2];
      3'd4:    ioByte = CMD_CONFIRM;
      default: ioByte = CMD_STATUS;
    endcase
  end

  assign isCmd = (idx == 3'd0) || (idx >= 3'(IDX_CONFIRM));

  // R3: the byte index never runs past the status command
  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    idx <= 3'(IDX_STATUS));

  // R9: a timed-out operation never reports pass
  assert_tmo_no_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> !pass);

endmodule

// File: rtl/nand_erase_ctrl.sv
module nand_erase_ctrl
  import nand_erase_pkg::*;
#(
  parameter int WE_LOW      = 2,
  parameter int WE_HIGH     = 2,
  parameter int WB_CYC      = 4,
  parameter int RE_LOW      = 3,
  parameter int TIMEOUT_CYC = 300,
  parameter int CNT_W       = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             rbN,
  input  logic [CNT_W-1:0] cnt,
  input  logic [2:0]       idx,
  input  logic             isCmd,
  output dpCtrl_t          ctl,
  output logic             busy,
  output logic             done,
  output logic             ceN,
  output logic             cle,
  output logic             ale,
  output logic             weN,
  output logic             reN,
  output logic             ioOe
);

  seqState_t state, nextState;
  logic      wrPhase;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    ctl.cntInc = 1'b1;
    case (state)
      ST_IDLE: begin
        ctl.cntInc = 1'b0;
        if (start) begin
          ctl.loadAddr = 1'b1;
          ctl.cntClr   = 1'b1;
          nextState    = ST_WR_LO;
        end
      end
      ST_WR_LO: if (cnt == CNT_W'(WE_LOW - 1)) begin
        ctl.cntClr = 1'b1;
        nextState  = ST_WR_HI;
      end
      ST_WR_HI: if (cnt == CNT_W'(WE_HIGH - 1)) begin
        ctl.cntClr = 1'b1;
        if (idx == 3'(IDX_CONFIRM)) begin
          ctl.idxInc = 1'b1;
          nextState  = ST_WAIT_WB;
        end else if (idx == 3'(IDX_STATUS)) begin
          nextState  = ST_RD_LO;
        end else begin
          ctl.idxInc = 1'b1;
          nextState  = ST_WR_LO;
        end
      end
      ST_WAIT_WB: if (cnt == CNT_W'(WB_CYC - 1)) begin
        ctl.cntClr = 1'b1;
        nextState  = ST_WAIT_RDY;
      end
      ST_WAIT_RDY: begin
        if (rbN) begin
          ctl.cntClr = 1'b1;
          nextState  = ST_WR_LO;
        end else if (cnt == CNT_W'(TIMEOUT_CYC - 1)) begin
          ctl.setTmo = 1'b1;
          nextState  = ST_FIN;
        end
      end
      ST_RD_LO: if (cnt == CNT_W'(RE_LOW - 1)) begin
        ctl.capStat = 1'b1;
        nextState   = ST_FIN;
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign wrPhase = (state == ST_WR_LO) || (state == ST_WR_HI);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FIN);
  assign ceN     = (state == ST_IDLE) || (state == ST_FIN);
  assign weN     = (state != ST_WR_LO);
  assign reN     = (state != ST_RD_LO);
  assign cle     = wrPhase & isCmd;
  assign ale     = wrPhase & ~isCmd;
  assign ioOe    = wrPhase;

  // R6: read-enable only drops once the status command is the current byte
  assert_read_after_status_R6: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> (idx == 3'(IDX_STATUS)));

  // R10: done is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int PAGE_BITS   = 6,
  parameter int WE_LOW      = 2,
  parameter int WE_HIGH     = 2,
  parameter int WB_CYC      = 4,
  parameter int RE_LOW      = 3,
  parameter int TIMEOUT_CYC = 300
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [23:0] rowAddr,
  input  logic        nandRbN,
  input  logic [7:0]  nandIoIn,
  output logic        busy,
  output logic        done,
  output logic        pass,
  output logic        wpFault,
  output logic        timeout,
  output logic        nandCeN,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic [7:0]  nandIoOut,
  output logic        nandIoOe
);

  localparam int MAX_A = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
  localparam int MAX_B = (WB_CYC > RE_LOW) ? WB_CYC : RE_LOW;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CNT = (MAX_C > TIMEOUT_CYC) ? MAX_C : TIMEOUT_CYC;
  localparam int CNT_W = $clog2(MAX_CNT + 1);

  dpCtrl_t          ctl;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       idx;
  logic             isCmd;

  nand_erase_ctrl #(
    .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .WB_CYC(WB_CYC),
    .RE_LOW(RE_LOW), .TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rbN(nandRbN),
    .cnt(cnt), .idx(idx), .isCmd(isCmd), .ctl(ctl),
    .busy(busy), .done(done), .ceN(nandCeN), .cle(nandCle),
    .ale(nandAle), .weN(nandWeN), .reN(nandReN), .ioOe(nandIoOe)
  );

  nand_erase_dp #(
    .PAGE_BITS(PAGE_BITS), .CNT_W(CNT_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rowAddr(rowAddr),
    .ioIn(nandIoIn), .cnt(cnt), .idx(idx), .ioByte(nandIoOut),
    .isCmd(isCmd), .pass(pass), .wpFault(wpFault), .timeout(timeout)
  );

  // R3: write strobe only while the chip is selected
  assert_we_needs_ce_R3: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> !nandCeN);

  // R3: command and address latches are exclusive
  assert_latch_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  // R1: chip deselected whenever idle
  assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> nandCeN);

  // R6: never read and write at once
  assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> nandWeN);

endmodule

// File: tb/test_nand_erase_seq.sv
module test_nand_erase_seq;

  localparam int PAGE_BITS   = 6;
  localparam int WE_LOW      = 2;
  localparam int WE_HIGH     = 2;
  localparam int WB_CYC      = 4;
  localparam int RE_LOW      = 3;
  localparam int TIMEOUT_CYC = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [23:0] rowAddr = '0;
  logic nandRbN = 1'b1;
  logic [7:0] nandIoIn;
  logic busy, done, pass, wpFault, timeout;
  logic nandCeN, nandCle, nandAle, nandWeN, nandReN, nandIoOe;
  logic [7:0] nandIoOut;

  always #10 clk = ~clk;

  nand_erase_seq #(
    .PAGE_BITS(PAGE_BITS), .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH),
    .WB_CYC(WB_CYC), .RE_LOW(RE_LOW), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_nand_erase_seq (
    .clk(clk), .rstN(rstN), .start(start), .rowAddr(rowAddr),
    .nandRbN(nandRbN), .nandIoIn(nandIoIn), .busy(busy), .done(done),
    .pass(pass), .wpFault(wpFault), .timeout(timeout), .nandCeN(nandCeN),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandIoOut(nandIoOut), .nandIoOe(nandIoOe)
  );

  int testsRun = 0;
  int testsFail = 0;

  // device model state
  logic [7:0]  statusByte = 8'hE0;
  int          busyLenCur = 10;
  logic [7:0]  wrByte [64];
  logic        wrCle [64];
  logic        wrAle [64];
  logic        wrRb [64];
  int          totWr = 0;
  int          d0Count = 0;
  int          lastD0 = 0;
  int          rbCnt = 0;
  int          weRun = 0;
  int          reRun = 0;
  int          badWidth = 0;

  assign nandIoIn = !nandReN ? statusByte : 8'hFF;

  always @(posedge nandWeN) begin
    if (!nandCeN) begin
      wrByte[totWr % 64] = nandIoOut;
      wrCle[totWr % 64]  = nandCle;
      wrAle[totWr % 64]  = nandAle;
      wrRb[totWr % 64]   = nandRbN;
      if (nandCle && nandIoOut == 8'hD0) d0Count = d0Count + 1;
      totWr = totWr + 1;
    end
  end

  always @(negedge clk) begin
    if (d0Count != lastD0) begin
      lastD0 = d0Count;
      rbCnt = busyLenCur;
      nandRbN <= 1'b0;
    end else if (rbCnt > 0) begin
      rbCnt = rbCnt - 1;
      if (rbCnt == 0) nandRbN <= 1'b1;
    end
    if (!nandWeN) weRun = weRun + 1;
    else if (weRun > 0) begin
      if (weRun != WE_LOW) badWidth = badWidth + 1;
      weRun = 0;
    end
    if (!nandReN) reRun = reRun + 1;
    else if (reRun > 0) begin
      if (reRun != RE_LOW) badWidth = badWidth + 1;
      reRun = 0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [23:0] row;
    logic [15:0] busyLen;
    logic [7:0]  stat;
    logic        ePass;
    logic        eWp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{24'h012345, 16'd20, 8'hE0, 1'b1, 1'b0},
    '{24'hFFFFFF, 16'd50, 8'hE1, 1'b0, 1'b0},
    '{24'h00003F, 16'd10, 8'h60, 1'b0, 1'b1},
    '{24'hABCDC0, 16'd1,  8'hC0, 1'b1, 1'b0},
    '{24'h123480, 16'd99, 8'h61, 1'b0, 1'b1}
  };

  task automatic runErase(input logic [23:0] row, input int busyLen,
                          input logic [7:0] stat, input bit ePass,
                          input bit eWp, input bit eTmo, input bit midStart);
    int base;
    int nWr;
    bit seen;
    bit seqOk;
    bit addrOk;
    logic [23:0] mrow;
    statusByte = stat;
    busyLenCur = busyLen;
    base = totWr;
    badWidth = 0;
    mrow = row & ~24'(((1 << PAGE_BITS) - 1));
    @(negedge clk);
    rowAddr = row;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", "busy after start", 32'(busy), 32'd1);
    seen = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      if (midStart && i == 8) begin
        rowAddr = ~row;
        start = 1'b1;
      end else start = 1'b0;
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    start = 1'b0;
    check(seen, "R10", "done reached", 32'(seen), 32'd1);
    check(timeout == eTmo, "R9", "timeout flag", 32'(timeout), 32'(eTmo));
    check(pass == ePass, "R7", "pass flag", 32'(pass), 32'(ePass));
    check(wpFault == eWp, "R8", "wpFault flag", 32'(wpFault), 32'(eWp));
    check(busy == 1'b1, "R10", "busy in done cycle", 32'(busy), 32'd1);
    nWr = totWr - base;
    check(nWr == (eTmo ? 5 : 6), midStart ? "R2" : "R3", "write count",
          32'(nWr), eTmo ? 32'd5 : 32'd6);
    seqOk = (wrByte[base % 64] == 8'h60) && wrCle[base % 64] && !wrAle[base % 64];
    for (int k = 1; k <= 3; k++)
      seqOk &= wrAle[(base + k) % 64] && !wrCle[(base + k) % 64];
    seqOk &= (wrByte[(base + 4) % 64] == 8'hD0) && wrCle[(base + 4) % 64];
    if (!eTmo) seqOk &= (wrByte[(base + 5) % 64] == 8'h70) && wrCle[(base + 5) % 64];
    check(seqOk, "R3", "command/latch order", 32'(wrByte[base % 64]), 32'h60);
    addrOk = 1'b1;
    for (int k = 0; k < 3; k++)
      addrOk &= (wrByte[(base + 1 + k) % 64] == mrow[8*k +: 8]);
    check(addrOk, "R4", "row bytes",
          {8'h0, wrByte[(base + 3) % 64], wrByte[(base + 2) % 64], wrByte[(base + 1) % 64]},
          32'(mrow));
    if (!eTmo)
      check(wrRb[(base + 5) % 64] == 1'b1, "R6", "ready before status cmd",
            32'(wrRb[(base + 5) % 64]), 32'd1);
    check(badWidth == 0, "R5", "strobe widths", 32'(badWidth), 32'd0);
    @(negedge clk);
    check(done == 1'b0, "R10", "done one cycle", 32'(done), 32'd0);
    repeat (5) @(negedge clk);
    check(busy == 1'b0, midStart ? "R2" : "R10", "idle after op", 32'(busy), 32'd0);
    check(pass == ePass && wpFault == eWp && timeout == eTmo, "R10", "flags held",
          {29'd0, pass, wpFault, timeout}, {29'd0, ePass, eWp, eTmo});
    if (eTmo) begin
      for (int i = 0; i < 500 && !nandRbN; i++) @(negedge clk);
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !pass && !wpFault && !timeout, "R1", "flags in reset",
          {27'd0, busy, done, pass, wpFault, timeout}, 32'd0);
    check(nandCeN && nandWeN && nandReN && !nandCle && !nandAle, "R1", "pins in reset",
          {27'd0, nandCeN, nandWeN, nandReN, nandCle, nandAle}, 32'h1C);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && nandCeN, "R1", "idle after reset", {30'd0, busy, nandCeN}, 32'd1);

    for (int v = 0; v < 5; v++)
      runErase(VECS[v].row, int'(VECS[v].busyLen), VECS[v].stat,
               VECS[v].ePass, VECS[v].eWp, 1'b0, 1'b0);

    // R2: start during an operation is ignored
    runErase(24'h5A5A5A, 40, 8'hE0, 1'b1, 1'b0, 1'b0, 1'b1);

    // R9: device never becomes ready within the window
    runErase(24'h0F0F00, TIMEOUT_CYC + 100, 8'hE0, 1'b0, 1'b0, 1'b1, 1'b0);

    // recovery after a timeout, flags cleared by the new start
    runErase(24'h000040, 5, 8'hE0, 1'b1, 1'b0, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule